// File: doc/BRIEF.md
# Reset and Configuration Restore Sequencer

This block decides, inside a configurable clock-distribution chip, when the register file is reloaded and when the clock outputs may start toggling. A reset can come from four sources: the supply monitor at power-up, an active-low asynchronous reset pin, a pair of self-clearing trigger bits in an 8-bit control register written over the serial port, and a separate request to reload from nonvolatile memory. Every reset ends with a one-cycle `restore_go` pulse to the register file. `restore_src` tells the register file whether to load from nonvolatile memory (strap high) or from the built-in defaults (strap low). The outputs are then held in sync for a wait whose length depends on the cause of the reset and on the strap.

All waits are counted in reference-clock cycles and set by parameters. The two asynchronous pins and the supply monitor assert at once. Their release passes through a two-flop synchronizer. A soft reset leaves the control register in place. Only its two trigger bits are self-clearing, and they clear on the next serial clock tick; internal reset stays high until then. An active-low power-down pin forces the outputs off but does not restore anything. A new request that arrives during a restore or a wait starts the sequence again from the beginning.

Top module: `restore_seq`

## Requirements
- R1: While `supply_ok` or `rst_pin_n` is low, `chip_rst` and `sync_hold` are 1, `outputs_enable` is 0 and `ctl_q` is 0, with no clock edge needed. When both inputs are high, the reset is released on the second clock edge.
- R2: After `supply_ok` rises, exactly one `restore_go` pulse occurs, and `restore_src` equals `strap_nvm` during it. `outputs_enable` rises at the clock edge that is POR_WAIT+4 edges after the release.
- R3: After `rst_pin_n` is released with `supply_ok` high, `outputs_enable` rises at the clock edge that is W+4 edges after the release. W is SHORT_WAIT when `strap_nvm`=0 and NVM_WAIT when `strap_nvm`=1.
- R4: A control write whose data has bit 2 and bit 5 both set starts a soft reset. `chip_rst` is 1 from the next edge, and `ctl_q` shows the written byte with bits 2 and 5 set.
- R5: During a soft reset, bits 2 and 5 of `ctl_q` and `chip_rst` stay 1 until an edge that samples `sclk_tick`=1. At that edge bits 2 and 5 clear, the other control bits are kept, and `restore_go` pulses. `outputs_enable` rises W+1 edges later, with W chosen by the strap as in R3.
- R6: A control write that does not set both bit 2 and bit 5 is stored with those two bits reading 0, and it causes no reset.
- R7: `reload_req`=1 with `strap_nvm`=1 produces a `restore_go` pulse with `restore_src`=1 on the next edge, and `outputs_enable` rises NVM_WAIT+1 edges after that. With `strap_nvm`=0 the request has no effect: there is no pulse and `outputs_enable` stays 1.
- R8: While `pd_pin_n` is low, `power_down` is 1 and `outputs_enable` is 0 immediately. Control writes are still accepted. When the pin is released, `outputs_enable` returns on the second edge, with no `restore_go` pulse.
- R9: A reload or soft-reset request made during the wait starts the sequence again. `outputs_enable` rises the full wait plus one edge after the edge of the new `restore_go` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| supply_ok | input | 1 | Supply monitor: 0 while below the threshold (power-on reset) |
| rst_pin_n | input | 1 | Asynchronous hard reset, active low |
| pd_pin_n | input | 1 | Power-down, active low |
| strap_nvm | input | 1 | Restore source strap: 1 nonvolatile memory, 0 defaults |
| ctl_we | input | 1 | Control register write strobe (one cycle) |
| ctl_wdata | input | CTL_W | Control register write data |
| sclk_tick | input | 1 | One serial clock cycle completed |
| reload_req | input | 1 | Write of the self-clearing reload-from-memory bit |
| ctl_q | output | CTL_W | Control register contents |
| chip_rst | output | 1 | Internal reset to the rest of the chip |
| restore_go | output | 1 | One-cycle command to reload the register file |
| restore_src | output | 1 | Source for restore_go: 1 memory, 0 defaults |
| sync_hold | output | 1 | Outputs held in sync |
| outputs_enable | output | 1 | Outputs may toggle |
| power_down | output | 1 | Chip held in power-down |

## Verification
The assertions assume that `ctl_we`, `sclk_tick` and `reload_req` are single-cycle pulses that are synchronous to `clk`. They also assume that `strap_nvm` does not change while a restore is being decided. They do not judge cycles in which a hard reset is asserted. The stimulus drives every pulse for one cycle from the falling edge. It changes the strap only while the sequencer is idle or held in reset, and it asserts and releases the asynchronous pins only on falling edges. This keeps the synchronizer latency used in the expected counts exact.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
    typedef enum logic [2:0] {
        ST_HOLD,
        ST_SOFT,
        ST_LOAD,
        ST_WAIT,
        ST_RUN
    } seq_st_e;

    typedef enum logic [1:0] {
        C_POR,
        C_PIN,
        C_SOFT,
        C_NVM
    } cause_e;
endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/rsq_timer.sv
module rsq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)              cnt_d = load_val;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/restore_seq.sv
module restore_seq #(
    parameter int CTL_W       = 8,
    parameter int TRIG_A      = 2,
    parameter int TRIG_B      = 5,
    parameter int POR_WAIT    = 7_000_000,
    parameter int SHORT_WAIT  = 200,
    parameter int NVM_WAIT    = 4_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             supply_ok,
    input  logic             rst_pin_n,
    input  logic             pd_pin_n,
    input  logic             strap_nvm,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             sclk_tick,
    input  logic             reload_req,
    output logic [CTL_W-1:0] ctl_q,
    output logic             chip_rst,
    output logic             restore_go,
    output logic             restore_src,
    output logic             sync_hold,
    output logic             outputs_enable,
    output logic             power_down
);
    import rsq_pkg::*;

    localparam logic [CTL_W-1:0] TRIG_MASK =
        (CTL_W'(1) << TRIG_A) | (CTL_W'(1) << TRIG_B);
    localparam int MAX_A    = (POR_WAIT > NVM_WAIT) ? POR_WAIT : NVM_WAIT;
    localparam int MAX_WAIT = (MAX_A > SHORT_WAIT) ? MAX_A : SHORT_WAIT;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);

    typedef struct packed {
        seq_st_e          st;
        cause_e           cause;
        logic [CTL_W-1:0] ctl;
    } seq_state_t;

    seq_state_t       s_d, s_q;
    logic             hard_arst_n, core_rst_n, por_rst_n, pd_n_s;
    logic             por_done_q;
    logic             tmr_load, tmr_done, trig_wr;
    logic [CNT_W-1:0] tmr_val;

    assign hard_arst_n = supply_ok & rst_pin_n;

    rsq_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
        .clk(clk), .arst_n(supply_ok), .rst_n_o(por_rst_n));
    rsq_sync #(.STAGES(SYNC_STAGES)) u_hard_sync (
        .clk(clk), .arst_n(hard_arst_n), .rst_n_o(core_rst_n));
    rsq_sync #(.STAGES(SYNC_STAGES)) u_pd_sync (
        .clk(clk), .arst_n(pd_pin_n), .rst_n_o(pd_n_s));

    rsq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(core_rst_n), .load(tmr_load),
        .load_val(tmr_val), .done(tmr_done));

    // Remembers that the first power-up sequence has run; only a supply drop clears it.
    always_ff @(posedge clk or negedge por_rst_n) begin
        if (!por_rst_n)      por_done_q <= 1'b0;
        else if (core_rst_n) por_done_q <= 1'b1;
    end

    assign trig_wr = ctl_we && ctl_wdata[TRIG_A] && ctl_wdata[TRIG_B];

    always_comb begin
        s_d      = s_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (s_q.st)
            ST_HOLD: begin
                s_d.st    = ST_LOAD;
                s_d.cause = por_done_q ? C_PIN : C_POR;
            end
            ST_SOFT: if (sclk_tick) s_d.st = ST_LOAD;
            ST_LOAD: begin
                s_d.st   = ST_WAIT;
                tmr_load = 1'b1;
                unique case (s_q.cause)
                    C_POR:   tmr_val = CNT_W'(POR_WAIT - 1);
                    C_NVM:   tmr_val = CNT_W'(NVM_WAIT - 1);
                    default: tmr_val = strap_nvm ? CNT_W'(NVM_WAIT - 1)
                                                 : CNT_W'(SHORT_WAIT - 1);
                endcase
            end
            ST_WAIT: if (tmr_done) s_d.st = ST_RUN;
            default: ;
        endcase
        if (s_q.st != ST_HOLD) begin
            if (trig_wr) begin
                s_d.st    = ST_SOFT;
                s_d.cause = C_SOFT;
            end else if (reload_req && strap_nvm && s_q.st != ST_SOFT) begin
                s_d.st    = ST_LOAD;
                s_d.cause = C_NVM;
            end
        end
        if (ctl_we) s_d.ctl = ctl_wdata;
        if (s_d.st == ST_SOFT) s_d.ctl = s_d.ctl | TRIG_MASK;
        else                   s_d.ctl = s_d.ctl & ~TRIG_MASK;
    end

    always_ff @(posedge clk or negedge core_rst_n) begin
        if (!core_rst_n) begin
            s_q.st    <= ST_HOLD;
            s_q.cause <= C_POR;
            s_q.ctl   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctl_q          = s_q.ctl;
    assign chip_rst       = (s_q.st == ST_HOLD) || (s_q.st == ST_SOFT) || (s_q.st == ST_LOAD);
    assign restore_go     = (s_q.st == ST_LOAD);
    assign restore_src    = restore_go && strap_nvm;
    assign sync_hold      = (s_q.st != ST_RUN);
    assign power_down     = !pd_n_s;
    assign outputs_enable = (s_q.st == ST_RUN) && pd_n_s;
endmodule

// File: rtl/restore_seq_chk.sv
module restore_seq_chk #(
    parameter int CTL_W  = 8,
    parameter int TRIG_A = 2,
    parameter int TRIG_B = 5
) (
    input logic             clk,
    input logic             core_rst_n,
    input logic [CTL_W-1:0] ctl_q,
    input logic             ctl_we,
    input logic             sclk_tick,
    input logic             reload_req,
    input logic             strap_nvm,
    input logic             chip_rst,
    input logic             restore_go,
    input logic             sync_hold,
    input logic             outputs_enable,
    input logic             power_down
);
    // R8: toggling outputs exclude reset, power-down and sync hold
    p_oe_excl_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
        outputs_enable |-> (!chip_rst && !power_down && !sync_hold));

    // R2: a restore command lasts one cycle unless a new request restarts it
    p_go_single_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
        (restore_go && !reload_req && !ctl_we) |=> !restore_go);

    // R5: set trigger bits keep the chip in reset
    p_trig_hold_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
        (ctl_q[TRIG_A] && ctl_q[TRIG_B]) |-> chip_rst);

    // R5: trigger bits clear only after a serial clock tick
    p_trig_clear_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
        $fell(ctl_q[TRIG_B]) |-> $past(sclk_tick));

    // R7: a reload request with the strap low starts nothing
    p_reload_ign_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
        (reload_req && !strap_nvm && !chip_rst && !ctl_we) |=> !restore_go);
endmodule

bind restore_seq restore_seq_chk #(.CTL_W(CTL_W), .TRIG_A(TRIG_A), .TRIG_B(TRIG_B)) u_chk (
    .clk(clk), .core_rst_n(core_rst_n), .ctl_q(ctl_q), .ctl_we(ctl_we),
    .sclk_tick(sclk_tick), .reload_req(reload_req), .strap_nvm(strap_nvm),
    .chip_rst(chip_rst), .restore_go(restore_go), .sync_hold(sync_hold),
    .outputs_enable(outputs_enable), .power_down(power_down));

// File: tb/restore_seq_test.sv
module restore_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 20;
    localparam int SW = 5;
    localparam int NW = 12;

    logic       clk = 1'b0;
    logic       supply_ok = 1'b0, rst_pin_n = 1'b1, pd_pin_n = 1'b1, strap_nvm = 1'b0;
    logic       ctl_we = 1'b0, sclk_tick = 1'b0, reload_req = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_q;
    logic       chip_rst, restore_go, restore_src, sync_hold, outputs_enable, power_down;

    int errors = 0;
    int checks = 0;
    int go_cnt = 0;
    logic last_src = 1'b0;

    restore_seq #(.POR_WAIT(PW), .SHORT_WAIT(SW), .NVM_WAIT(NW)) uut (
        .clk(clk), .supply_ok(supply_ok), .rst_pin_n(rst_pin_n), .pd_pin_n(pd_pin_n),
        .strap_nvm(strap_nvm), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .sclk_tick(sclk_tick), .reload_req(reload_req), .ctl_q(ctl_q),
        .chip_rst(chip_rst), .restore_go(restore_go), .restore_src(restore_src),
        .sync_hold(sync_hold), .outputs_enable(outputs_enable), .power_down(power_down));

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (restore_go) begin
            go_cnt   = go_cnt + 1;
            last_src = restore_src;
        end
    end

    // {trigger expected, ctl_q after write, write data}
    localparam logic [16:0] VEC [6] = '{
        {1'b0, 8'hDB, 8'hDB},
        {1'b0, 8'h00, 8'h04},
        {1'b0, 8'h00, 8'h20},
        {1'b0, 8'h5A, 8'h5A},
        {1'b1, 8'h24, 8'h24},
        {1'b1, 8'hE7, 8'hE7}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
        @(posedge clk); #1 ctl_we = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); sclk_tick = 1'b1;
        @(posedge clk); #1 sclk_tick = 1'b0;
    endtask

    task automatic reload();
        @(negedge clk); reload_req = 1'b1;
        @(posedge clk); #1 reload_req = 1'b0;
    endtask

    task automatic wait_oe(input int start, output int n);
        n = start;
        while (!outputs_enable && n < 2000) begin
            @(posedge clk); #1;
            n++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++; checks++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n, g;
        #2;
        // R1: reset state under power-on
        chk("R1 chip_rst", chip_rst, 1);
        chk("R1 oe", outputs_enable, 0);
        chk("R1 sync_hold", sync_hold, 1);
        chk("R1 ctl_q", ctl_q, 0);
        // R2: power-on with defaults
        @(negedge clk); supply_ok = 1'b1;
        wait_oe(0, n);
        chk("R2 por wait", n, PW + 4);
        chk("R2 go count", go_cnt, 1);
        chk("R2 src", last_src, 0);

        // R4 R5 R6: control write table
        for (int i = 0; i < 6; i++) begin
            g = go_cnt;
            wr(VEC[i][7:0]);
            chk("R4/R6 ctl_q", ctl_q, VEC[i][15:8]);
            chk("R4/R6 chip_rst", chip_rst, VEC[i][16]);
            if (VEC[i][16]) begin
                repeat (3) @(posedge clk);
                #1 chk("R5 held until tick", chip_rst, 1);
                chk("R5 bits held", ctl_q, VEC[i][15:8]);
                tick();
                chk("R5 go on tick", restore_go, 1);
                chk("R5 bits cleared", ctl_q, VEC[i][15:8] & 8'hDB);
                wait_oe(0, n);
                chk("R5 soft wait", n, SW + 1);
                chk("R5 ctl kept", ctl_q, VEC[i][15:8] & 8'hDB);
            end else begin
                repeat (3) @(posedge clk);
                #1 chk("R6 no reset", outputs_enable, 1);
                chk("R6 no restore", go_cnt, g);
            end
        end

        // R3: pin reset, strap low then high
        for (int s = 0; s < 2; s++) begin
            @(negedge clk); strap_nvm = s[0]; rst_pin_n = 1'b0;
            #1 chk("R1 pin chip_rst", chip_rst, 1);
            chk("R1 pin oe", outputs_enable, 0);
            chk("R1 pin ctl", ctl_q, 0);
            repeat (3) @(negedge clk);
            rst_pin_n = 1'b1;
            wait_oe(0, n);
            chk("R3 pin wait", n, (s == 0 ? SW : NW) + 4);
            chk("R3 src", last_src, s);
        end

        // R7: reload with strap high
        g = go_cnt;
        reload();
        chk("R7 go", restore_go, 1);
        wait_oe(0, n);
        chk("R7 reload wait", n, NW + 1);
        chk("R7 go count", go_cnt, g + 1);
        chk("R7 src", last_src, 1);

        // R7: reload ignored with strap low
        @(negedge clk); strap_nvm = 1'b0;
        g = go_cnt;
        reload();
        repeat (5) @(posedge clk);
        #1 chk("R7 ignored oe", outputs_enable, 1);
        chk("R7 ignored go", go_cnt, g);

        // R9: restart during the wait
        @(negedge clk); strap_nvm = 1'b1;
        reload();
        repeat (5) @(posedge clk);
        #1 chk("R9 still waiting", outputs_enable, 0);
        reload();
        wait_oe(0, n);
        chk("R9 restart wait", n, NW + 1);

        // R8: power-down
        g = go_cnt;
        @(negedge clk); pd_pin_n = 1'b0;
        #1 chk("R8 pd flag", power_down, 1);
        chk("R8 pd oe", outputs_enable, 0);
        wr(8'h81);
        chk("R8 write in pd", ctl_q, 8'h81);
        repeat (2) @(negedge clk);
        pd_pin_n = 1'b1;
        wait_oe(0, n);
        chk("R8 release", n, 2);
        chk("R8 no restore", go_cnt, g);
        chk("R8 ctl kept", ctl_q, 8'h81);

        // R2: power-on again with strap high
        @(negedge clk); supply_ok = 1'b0;
        g = go_cnt;
        #1 chk("R1 supply ctl", ctl_q, 0);
        repeat (2) @(negedge clk);
        supply_ok = 1'b1;
        wait_oe(0, n);
        chk("R2 por wait strap", n, PW + 4);
        chk("R2 src strap", last_src, 1);
        chk("R2 single go", go_cnt, g + 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule